// File: doc/BRIEF.md
# Flag-Generating Integer ALU

This unit performs the data-processing operations of a compact 16-bit instruction set on 32-bit operands. On each issue cycle it receives an operation code, operand A, operand B and the current condition flags. Operand A is the destination register's old value. Operand B is either a second register or an immediate that was zero-extended before it reached the unit. One clock later the unit presents the result, a write strobe for the destination register and the updated flags.

The operations are add, subtract, add-with-carry, subtract-with-carry, negate, the compare family (compare, compare-negative and test), the bitwise operations AND, EOR, ORR, bit-clear and move-not, a low-word multiply, and a move of operand B. The arithmetic operations share one adder. Subtraction runs on that adder as A plus the inverted B plus a carry-in, so the carry out is an inverted borrow. The bitwise operations and the multiply refresh only N and Z.

Top module: `flagged_alu`

## Requirements
- R1: An issue (`issue_vld`=1) at clock edge k drives `res_vld`=1 and the registered outputs after edge k. With no issue at an edge, `res_vld` and `rd_we` are 0 after that edge.
- R2: While `rst_n`=0, `res_q`, `flags_q`, `rd_we` and `res_vld` are all 0.
- R3: Flags are packed as [3]=N, [2]=Z, [1]=C, [0]=V. ADD (code 8) and CMN (code 14) form A+B. N is bit 31 of the sum, Z is set when the sum is zero, C is the unsigned carry out of bit 31 and V is signed overflow.
- R4: SUB (code 9) and CMP (code 13) form A−B. C is 1 when A ≥ B unsigned, V is the signed overflow of A−B, and N and Z follow the result.
- R5: ADC (code 10) yields A+B+C_in with the addition flags. SBC (code 11) yields A−B−(1−C_in), with C equal to the carry out of A + NOT B + C_in and V as for subtraction.
- R6: NEG (code 12) yields 0−B and ignores A. Its flags follow the subtraction rules, so C=1 only when B=0.
- R7: CMP, CMN and TST (code 7) never assert `rd_we`. They still update the flags and show the computed value on `res_q`.
- R8: AND (0), EOR (1), ORR (2), BIC (3, A AND NOT B), MVN (4, NOT B) and TST set N and Z from the result and copy C and V from the incoming flags.
- R9: MUL (code 5) yields the low 32 bits of A×B. N and Z follow those bits, and C and V are copied from the incoming flags.
- R10: MOV (code 6) yields B unchanged and writes the destination. N and Z follow B, and C and V are kept.
- R11: Code 15 is reserved. It gives `rd_we`=0 and `res_q`=0, and passes the incoming flags through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_vld | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation selector |
| opnd_a | input | 32 | Destination's old value |
| opnd_b | input | 32 | Second register or zero-extended immediate |
| flags_in | input | 4 | Current NZCV flags |
| res_q | output | 32 | Registered result |
| rd_we | output | 1 | Destination write strobe |
| flags_q | output | 4 | Updated NZCV flags |
| res_vld | output | 1 | Outputs belong to an issued operation |

## Verification
The hardest cases to reach are those where the carry-in changes the flags. Examples are subtract-with-carry with a clear carry, which moves the unsigned borrow boundary, and add-with-carry on an all-ones operand, where the carry alone causes the wrap. These are not reached by chance. The vector table pins them with hand-chosen operands and flag inputs. It also places signed-overflow boundaries such as 0x7FFFFFFF+1 and 0x80000000−1 next to values that differ only in the incoming C and V, so that any leak of the old flags is exposed.

// File: rtl/flagged_alu_pkg.sv
package flagged_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,
    OP_EOR = 4'd1,
    OP_ORR = 4'd2,
    OP_BIC = 4'd3,
    OP_MVN = 4'd4,
    OP_MUL = 4'd5,
    OP_MOV = 4'd6,
    OP_TST = 4'd7,
    OP_ADD = 4'd8,
    OP_SUB = 4'd9,
    OP_ADC = 4'd10,
    OP_SBC = 4'd11,
    OP_NEG = 4'd12,
    OP_CMP = 4'd13,
    OP_CMN = 4'd14,
    OP_RSV = 4'd15
  } alu_op_e;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  // Arithmetic ops all carry bit 3 of the code, except the reserved one.
  function automatic logic op_is_arith(input logic [3:0] op);
    return op[3] && (op != OP_RSV);
  endfunction

  function automatic logic op_writes(input logic [3:0] op);
    return !(op == OP_CMP || op == OP_CMN || op == OP_TST || op == OP_RSV);
  endfunction

endpackage

// File: rtl/fa_adder.sv
module fa_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         inv_y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] y_eff;
  logic [W:0]   wide;

  function automatic logic [W:0] add_wide(input logic [W-1:0] p,
                                          input logic [W-1:0] q,
                                          input logic c);
    return {1'b0, p} + {1'b0, q} + {{W{1'b0}}, c};
  endfunction

  always_comb begin
    y_eff = inv_y ? ~y : y;
    wide  = add_wide(x, y_eff, cin);
    sum   = wide[W-1:0];
    cout  = wide[W];
    ovf   = (x[W-1] == y_eff[W-1]) && (wide[W-1] != x[W-1]);
  end
endmodule

// File: rtl/fa_logic.sv
module fa_logic #(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  import flagged_alu_pkg::*;

  always_comb begin
    unique case (op)
      OP_AND, OP_TST: y = a & b;
      OP_EOR:         y = a ^ b;
      OP_ORR:         y = a | b;
      OP_BIC:         y = a & ~b;
      OP_MVN:         y = ~b;
      OP_MOV:         y = b;
      default:        y = '0;
    endcase
  end
endmodule

// File: rtl/fa_mul.sv
module fa_mul #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] lo
);
  localparam int PW = 2 * W;
  logic [PW-1:0] full;

  always_comb begin
    full = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    lo   = full[W-1:0];
  end
endmodule

// File: rtl/flagged_alu.sv
module flagged_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         issue_vld,
  input  logic [3:0]   op_code,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [3:0]   flags_in,
  output logic [W-1:0] res_q,
  output logic         rd_we,
  output logic [3:0]   flags_q,
  output logic         res_vld
);
  import flagged_alu_pkg::*;

  localparam int MSB = W - 1;

  // Named internal events, visible to the bound checker.
  logic [W-1:0] add_x, add_sum, logic_y, mul_lo, res_d;
  logic         add_inv, add_cin, add_cout, add_ovf;
  logic         is_arith, is_mul, is_rsv, does_write;
  logic [3:0]   flags_d;

  assign is_arith   = op_is_arith(op_code);
  assign is_mul     = (op_code == OP_MUL);
  assign is_rsv     = (op_code == OP_RSV);
  assign does_write = op_writes(op_code);

  always_comb begin
    add_x   = opnd_a;
    add_inv = 1'b0;
    add_cin = 1'b0;
    unique case (op_code)
      OP_SUB, OP_CMP: begin add_inv = 1'b1; add_cin = 1'b1; end
      OP_ADC:         add_cin = flags_in[FLAG_C];
      OP_SBC:         begin add_inv = 1'b1; add_cin = flags_in[FLAG_C]; end
      OP_NEG:         begin add_x = '0; add_inv = 1'b1; add_cin = 1'b1; end
      default:        ;
    endcase
  end

  fa_adder #(.W(W)) u_add (
    .x(add_x), .y(opnd_b), .inv_y(add_inv), .cin(add_cin),
    .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
  );

  fa_logic #(.W(W)) u_log (
    .op(op_code), .a(opnd_a), .b(opnd_b), .y(logic_y)
  );

  fa_mul #(.W(W)) u_mul (
    .a(opnd_a), .b(opnd_b), .lo(mul_lo)
  );

  always_comb begin
    if (is_arith)      res_d = add_sum;
    else if (is_mul)   res_d = mul_lo;
    else if (is_rsv)   res_d = '0;
    else               res_d = logic_y;

    if (is_rsv) begin
      flags_d = flags_in;
    end else begin
      flags_d[FLAG_N] = res_d[MSB];
      flags_d[FLAG_Z] = (res_d == '0);
      flags_d[FLAG_C] = is_arith ? add_cout : flags_in[FLAG_C];
      flags_d[FLAG_V] = is_arith ? add_ovf  : flags_in[FLAG_V];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q   <= '0;
      flags_q <= '0;
      rd_we   <= 1'b0;
      res_vld <= 1'b0;
    end else begin
      res_vld <= issue_vld;
      rd_we   <= issue_vld && does_write;
      if (issue_vld) begin
        res_q   <= res_d;
        flags_q <= flags_d;
      end
    end
  end
endmodule

// File: rtl/flagged_alu_chk.sv
module flagged_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         issue_vld,
  input logic [3:0]   op_code,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [3:0]   flags_in,
  input logic [W-1:0] res_q,
  input logic         rd_we,
  input logic [3:0]   flags_q,
  input logic         res_vld
);
  // R1: no issue means no valid and no write on the next cycle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_vld |=> (!res_vld && !rd_we));

  // R1: an issue yields a valid result next cycle
  a_r1_issue_valid: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |=> res_vld);

  // R3: addition carry equals the unsigned overflow of A+B
  a_r3_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && op_code == 4'd8) |=>
      (flags_q[1] == ((({1'b0, $past(opnd_a)} + {1'b0, $past(opnd_b)}) >> W) != 0)));

  // R4: subtraction carry is set exactly when no borrow occurs
  a_r4_sub_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && (op_code == 4'd9 || op_code == 4'd13)) |=>
      (flags_q[1] == ($past(opnd_a) >= $past(opnd_b))));

  // R7: compares and test never write the destination
  a_r7_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && (op_code == 4'd13 || op_code == 4'd14 || op_code == 4'd7)) |=> !rd_we);

  // R8 / R9 / R10: bitwise, multiply and move keep C and V
  a_r8_keep_cv: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && op_code < 4'd8) |=> (flags_q[1:0] == $past(flags_in[1:0])));

  // R8: N and Z agree with the presented result for non-reserved ops
  a_r8_nz_match: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && op_code != 4'd15) |=>
      (flags_q[3] == res_q[W-1] && flags_q[2] == (res_q == '0)));

  // R11: reserved code passes the flags and does not write
  a_r11_rsv_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && op_code == 4'd15) |=> (flags_q == $past(flags_in) && !rd_we));
endmodule

bind flagged_alu flagged_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .op_code(op_code),
  .opnd_a(opnd_a), .opnd_b(opnd_b), .flags_in(flags_in), .res_q(res_q),
  .rd_we(rd_we), .flags_q(flags_q), .res_vld(res_vld)
);

// File: tb/tb_flagged_alu.sv
module tb_flagged_alu;
  localparam int W    = 32;
  localparam int NVEC = 27;
  // row: op(4) a(32) b(32) fin(4) exp_res(32) exp_we(1) exp_flags(4)
  localparam int RW = 109;

  localparam logic [RW-1:0] VEC [0:NVEC-1] = '{
    {4'd8,  32'h00000001, 32'h00000002, 4'h0, 32'h00000003, 1'b1, 4'h0}, // R3
    {4'd8,  32'hFFFFFFFF, 32'h00000001, 4'h0, 32'h00000000, 1'b1, 4'h6}, // R3 carry
    {4'd8,  32'h7FFFFFFF, 32'h00000001, 4'h0, 32'h80000000, 1'b1, 4'h9}, // R3 overflow
    {4'd9,  32'h00000005, 32'h00000003, 4'h0, 32'h00000002, 1'b1, 4'h2}, // R4
    {4'd9,  32'h00000003, 32'h00000005, 4'h2, 32'hFFFFFFFE, 1'b1, 4'h8}, // R4 borrow
    {4'd9,  32'h80000000, 32'h00000001, 4'h0, 32'h7FFFFFFF, 1'b1, 4'h3}, // R4 overflow
    {4'd10, 32'h00000001, 32'h00000001, 4'h2, 32'h00000003, 1'b1, 4'h0}, // R5 adc
    {4'd10, 32'hFFFFFFFF, 32'h00000000, 4'h2, 32'h00000000, 1'b1, 4'h6}, // R5 adc wrap
    {4'd10, 32'h00000001, 32'h00000001, 4'h0, 32'h00000002, 1'b1, 4'h0}, // R5 adc no carry
    {4'd11, 32'h00000005, 32'h00000003, 4'h0, 32'h00000001, 1'b1, 4'h2}, // R5 sbc c=0
    {4'd11, 32'h00000005, 32'h00000003, 4'h2, 32'h00000002, 1'b1, 4'h2}, // R5 sbc c=1
    {4'd11, 32'h00000003, 32'h00000003, 4'h0, 32'hFFFFFFFF, 1'b1, 4'h8}, // R5 sbc borrow
    {4'd12, 32'h00001234, 32'h00000001, 4'h0, 32'hFFFFFFFF, 1'b1, 4'h8}, // R6
    {4'd12, 32'hDEADBEEF, 32'h00000000, 4'h0, 32'h00000000, 1'b1, 4'h6}, // R6 zero
    {4'd13, 32'h00000007, 32'h00000007, 4'h0, 32'h00000000, 1'b0, 4'h6}, // R7 cmp
    {4'd14, 32'hFFFFFFFF, 32'h00000001, 4'h0, 32'h00000000, 1'b0, 4'h6}, // R7 cmn
    {4'd7,  32'h000000F0, 32'h0000000F, 4'h3, 32'h00000000, 1'b0, 4'h7}, // R7 tst
    {4'd0,  32'hFF00FF00, 32'hF0F0F0F0, 4'h3, 32'hF000F000, 1'b1, 4'hB}, // R8 and
    {4'd1,  32'hFFFFFFFF, 32'hFFFFFFFF, 4'h2, 32'h00000000, 1'b1, 4'h6}, // R8 eor
    {4'd2,  32'h00000001, 32'h80000000, 4'h1, 32'h80000001, 1'b1, 4'h9}, // R8 orr
    {4'd3,  32'h0000FFFF, 32'h000000FF, 4'h0, 32'h0000FF00, 1'b1, 4'h0}, // R8 bic
    {4'd4,  32'h12345678, 32'h00000000, 4'h2, 32'hFFFFFFFF, 1'b1, 4'hA}, // R8 mvn
    {4'd5,  32'h00000003, 32'h00000005, 4'h3, 32'h0000000F, 1'b1, 4'h3}, // R9
    {4'd5,  32'h00010000, 32'h00010000, 4'h0, 32'h00000000, 1'b1, 4'h4}, // R9 wrap
    {4'd6,  32'h11111111, 32'h00000000, 4'h3, 32'h00000000, 1'b1, 4'h7}, // R10
    {4'd6,  32'h11111111, 32'h000000FF, 4'hC, 32'h000000FF, 1'b1, 4'h0}, // R10 imm
    {4'd15, 32'h00000001, 32'h00000002, 4'hA, 32'h00000000, 1'b0, 4'hA}  // R11
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         issue_vld = 1'b0;
  logic [3:0]   op_code = '0;
  logic [W-1:0] opnd_a = '0, opnd_b = '0;
  logic [3:0]   flags_in = '0;
  logic [W-1:0] res_q;
  logic         rd_we;
  logic [3:0]   flags_q;
  logic         res_vld;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flagged_alu #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .flags_in(flags_in), .res_q(res_q),
    .rd_we(rd_we), .flags_q(flags_q), .res_vld(res_vld)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic [3:0] f);
    @(negedge clk);
    issue_vld = 1'b1; op_code = op; opnd_a = a; opnd_b = b; flags_in = f;
    @(posedge clk); #1;
    @(negedge clk);
    issue_vld = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R2 res", {32'h0, res_q}, 64'h0);
    check("R2 flags", {60'h0, flags_q}, 64'h0);
    check("R2 we/vld", {62'h0, rd_we, res_vld}, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      logic [RW-1:0] v;
      v = VEC[i];
      @(negedge clk);
      issue_vld = 1'b1;
      op_code  = v[108:105];
      opnd_a   = v[104:73];
      opnd_b   = v[72:41];
      flags_in = v[40:37];
      @(posedge clk); #1;
      check($sformatf("R1 vld row %0d", i), {63'h0, res_vld}, 64'h1);
      check($sformatf("R3-R11 res row %0d", i), {32'h0, res_q}, {32'h0, v[36:5]});
      check($sformatf("R7 we row %0d", i), {63'h0, rd_we}, {63'h0, v[4]});
      check($sformatf("R3 flags row %0d", i), {60'h0, flags_q}, {60'h0, v[3:0]});
    end

    // R1: idle cycle drops valid and write, result held
    @(negedge clk);
    issue_vld = 1'b0;
    op_code = 4'd8; opnd_a = 32'h5; opnd_b = 32'h5;
    @(posedge clk); #1;
    check("R1 idle vld", {63'h0, res_vld}, 64'h0);
    check("R1 idle we", {63'h0, rd_we}, 64'h0);

    // R6: NEG ignores A
    issue(4'd12, 32'hFFFF0000, 32'h00000010, 4'h0);
    check("R6 neg ignores A", {32'h0, res_q}, 64'h00000000FFFFFFF0);

    // R5: SBC with C=0 at A==B gives all ones and borrow
    issue(4'd11, 32'h80000000, 32'h80000000, 4'h0);
    check("R5 sbc eq", {28'h0, flags_q, res_q}, {28'h0, 4'h8, 32'hFFFFFFFF});

    // R2: reset mid-run clears outputs
    @(negedge clk);
    issue_vld = 1'b1; op_code = 4'd8; opnd_a = 32'h1; opnd_b = 32'h1;
    rst_n = 1'b0;
    @(posedge clk); #1;
    check("R2 mid reset", {28'h0, flags_q, res_q}, 64'h0);
    check("R2 mid reset we", {62'h0, rd_we, res_vld}, 64'h0);
    @(negedge clk);
    issue_vld = 1'b0; rst_n = 1'b1;
    @(posedge clk); #1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule